// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a down-counting interval timer that raises a periodic interrupt. It counts once for each cycle on which the `tick` input is high. The tick is normally a 1 MHz enable, so each step is 1 µs. Software programs three registers through a simple register port. The modulus register sets the period. The control/status register holds the enables, the flag and the interrupt level. A read-only live-count register shows where the counter is now. When the count has reached zero and another tick arrives, the counter reloads from the modulus and a sticky status flag is set. The time between timeouts is therefore modulus + 1 ticks. A modulus of 33000 gives roughly 33 ms.

The interrupt request leaves the block on eight level lines. Software picks the level by writing a one-hot pattern into the level byte of the control register. The pattern appears on the request lines only while the flag is set and interrupts are enabled. A separate freeze input, usually tied to a debug-halt signal, can stop the counter. It does so only when software has allowed it through the freeze bit.

Top module: `periodic_timer`

## Requirements
- R1: After reset the control, modulus and live-count registers all read zero and `irqReq` is zero.
- R2: Register addresses on `regAddr` are: 0 control/status, 1 modulus, 2 live count, 3 reads zero. Control layout (LSB numbering): [15:8] level, [7] flag, [2] interrupt enable, [1] freeze allow, [0] timer enable. Bits [6:3] always read zero. Control and modulus read back on `regRdData[15:0]` with the upper half zero.
- R3: A control write that takes the timer enable from 0 to 1 loads the counter from the modulus register. While the timer enable is 0 the count holds.
- R4: While enabled, the count drops by exactly one per `tick` cycle and never changes on a cycle without `tick`.
- R5: A tick with the count at zero reloads the modulus and sets the flag, so timeouts occur every modulus + 1 ticks.
- R6: Writing 1 to control bit 7 clears the flag. Writing 0 there leaves it unchanged. If a timeout and a clearing write fall on the same cycle, the flag ends set.
- R7: `irqReq` equals the level byte ANDed with (flag AND interrupt enable). Bit 7 is level 0 (pattern 0x80) and bit 0 is level 7 (pattern 0x01).
- R8: With freeze allow set, ticks are ignored while `freezeIn` is high. With freeze allow clear, `freezeIn` has no effect.
- R9: The live-count register returns the count in bits [31:16] and zero in [15:0]. Writes to address 2 change no register.
- R10: A modulus write while running leaves the current count alone and takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| freezeIn | input | 1 | Debug freeze request |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| irqReq | output | 8 | Level request lines, bit 7 = level 0 |

## Verification
The bench measures the period tick by tick and checks that the flag is still clear one tick before the timeout. A counter that reloads one tick early, or that wraps to 0xFFFF, therefore gets caught. It places a clearing write on the same cycle as a timeout, so a design that lets the clear win loses that interrupt and is reported. It also rewrites the modulus mid-period and re-enables a stopped timer. These two cases catch a reload that happens at the wrong moment. With freeze allowed and `freezeIn` high, any step is flagged. With freeze not allowed, a missing step is flagged too.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int LVL_N   = 8;
  localparam int LVL_LSB = 8;
  localparam int BIT_FLG = 7;
  localparam int BIT_IE  = 2;
  localparam int BIT_FRZ = 1;
  localparam int BIT_EN  = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MOD  = 2'd1,
    ADDR_LIVE = 2'd2,
    ADDR_NONE = 2'd3
  } ptmr_addr_e;

  typedef struct packed {
    logic loadCount;
    logic stepCount;
    logic writeModulus;
  } ptmr_strobe_t;
endpackage

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptmr_strobe_t     strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] modulus,
  output logic             wrapEvt
);
  logic countIsZero;
  assign countIsZero = (count == '0);
  assign wrapEvt = strobe.stepCount && !strobe.loadCount && countIsZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modulus <= '0;
    end else if (strobe.writeModulus) begin
      modulus <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadCount) begin
      count <= modulus;
    end else if (strobe.stepCount) begin
      if (countIsZero) count <= modulus;
      else             count <= count - 1'b1;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCount && !strobe.stepCount) |=> $stable(count));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepCount && !strobe.loadCount && !countIsZero) |=>
      (count == CNT_W'($past(count) - 1'b1)));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (count == $past(modulus)));
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              freezeIn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrapEvt,
  output ptmr_strobe_t      strobe,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [LVL_N-1:0]  irqReq
);
  logic [LVL_N-1:0] levelQ;
  logic flagQ, ieQ, frzQ, enQ;
  logic wrCtrl, wrMod, clrReq;
  logic unusedReserved;

  assign unusedReserved = ^wrData[BIT_FLG-1:BIT_IE+1];
  assign wrCtrl = regWrEn && (ptmr_addr_e'(regAddr) == ADDR_CTRL);
  assign wrMod  = regWrEn && (ptmr_addr_e'(regAddr) == ADDR_MOD);
  assign clrReq = wrCtrl && wrData[BIT_FLG];

  always_comb begin
    strobe.loadCount    = wrCtrl && wrData[BIT_EN] && !enQ;
    strobe.stepCount    = tick && enQ && !(frzQ && freezeIn);
    strobe.writeModulus = wrMod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      ieQ    <= 1'b0;
      frzQ   <= 1'b0;
      enQ    <= 1'b0;
    end else if (wrCtrl) begin
      levelQ <= wrData[LVL_LSB +: LVL_N];
      ieQ    <= wrData[BIT_IE];
      frzQ   <= wrData[BIT_FRZ];
      enQ    <= wrData[BIT_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       flagQ <= 1'b0;
    else if (wrapEvt) flagQ <= 1'b1;
    else if (clrReq)  flagQ <= 1'b0;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[LVL_LSB +: LVL_N] = levelQ;
    ctrlWord[BIT_FLG] = flagQ;
    ctrlWord[BIT_IE]  = ieQ;
    ctrlWord[BIT_FRZ] = frzQ;
    ctrlWord[BIT_EN]  = enQ;
  end

  assign irqReq = levelQ & {LVL_N{flagQ && ieQ}};

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> flagQ);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ);

  assert_no_step_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !strobe.stepCount);
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               freezeIn,
  input  logic [1:0]         regAddr,
  input  logic               regWrEn,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [2*CNT_W-1:0] regRdData,
  output logic [LVL_N-1:0]   irqReq
);
  ptmr_strobe_t strobe;
  logic [CNT_W-1:0] count, modulus, ctrlWord;
  logic wrapEvt;

  ptmr_ctrl #(.DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .freezeIn(freezeIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .wrData(regWrData),
    .wrapEvt(wrapEvt), .strobe(strobe), .ctrlWord(ctrlWord), .irqReq(irqReq)
  );

  ptmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .count(count), .modulus(modulus), .wrapEvt(wrapEvt)
  );

  always_comb begin
    unique case (ptmr_addr_e'(regAddr))
      ADDR_CTRL: regRdData = {{CNT_W{1'b0}}, ctrlWord};
      ADDR_MOD:  regRdData = {{CNT_W{1'b0}}, modulus};
      ADDR_LIVE: regRdData = {count, {CNT_W{1'b0}}};
      default:   regRdData = '0;
    endcase
  end

  assert_live_low_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ptmr_addr_e'(regAddr) == ADDR_LIVE) |-> (regRdData[CNT_W-1:0] == '0));
endmodule

// File: tb/periodic_timer_bench.sv
module periodic_timer_bench;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, freezeIn = 1'b0, regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [31:0] regRdData;
  logic [7:0] irqReq;
  int checks = 0, errors = 0, cycles = 0;

  periodic_timer u_periodic_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .freezeIn(freezeIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; freezeIn = 1'b0; regWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic live(input string req, input logic [15:0] exp);
    logic [31:0] d;
    rd(2'd2, d);
    chk(req, d, {exp, 16'h0});
  endtask

  task automatic flag(input string req, input logic exp);
    logic [31:0] d;
    rd(2'd0, d);
    chk(req, {31'h0, d[7]}, {31'h0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reset read", d, 32'h0);
    end
    chk("R1 reset irq", {24'h0, irqReq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    doReset();
    wr(2'd0, 16'hFF7F);
    rd(2'd0, d); chk("R2 ctrl readback", d, 32'h0000FF07);
    wr(2'd1, 16'hBEEF);
    rd(2'd1, d); chk("R2 modulus readback", d, 32'h0000BEEF);
    rd(2'd3, d); chk("R2 addr3 zero", d, 32'h0);
  endtask

  task automatic t_period();
    doReset();
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h8005);
    live("R3 load on enable", 16'd3);
    repeat (5) @(negedge clk);
    live("R4 no tick hold", 16'd3);
    ticks(1); live("R4 step 1", 16'd2);
    ticks(2); live("R4 step to 0", 16'd0);
    flag("R5 flag clear before timeout", 1'b0);
    chk("R7 irq idle", {24'h0, irqReq}, 32'h0);
    ticks(1); live("R5 reload", 16'd3);
    flag("R5 flag set", 1'b1);
    chk("R7 irq level0", {24'h0, irqReq}, 32'h80);
    wr(2'd0, 16'h8085);
    flag("R6 w1c clear", 1'b0);
    chk("R7 irq after clear", {24'h0, irqReq}, 32'h0);
    ticks(3); flag("R5 no flag at 3 ticks", 1'b0);
    ticks(1); flag("R5 flag at 4 ticks", 1'b1);
    wr(2'd0, 16'h8005);
    flag("R6 write 0 keeps flag", 1'b1);
  endtask

  task automatic t_collide();
    doReset();
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0001);
    ticks(2);
    flag("R5 flag after wrap", 1'b1);
    ticks(1); live("R4 at zero", 16'd0);
    @(negedge clk);
    tick = 1'b1; regAddr = 2'd0; regWrData = 16'h0081; regWrEn = 1'b1;
    @(negedge clk);
    tick = 1'b0; regWrEn = 1'b0;
    flag("R6 set wins over clear", 1'b1);
    live("R5 reload on collide", 16'd1);
  endtask

  task automatic t_irq();
    doReset();
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h1001);
    ticks(1);
    flag("R5 flag with modulus 0", 1'b1);
    chk("R7 irq masked by ie", {24'h0, irqReq}, 32'h0);
    wr(2'd0, 16'h1005);
    chk("R7 irq level3", {24'h0, irqReq}, 32'h10);
  endtask

  task automatic t_freeze();
    doReset();
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0003);
    freezeIn = 1'b1;
    ticks(3); live("R8 frozen", 16'd5);
    freezeIn = 1'b0;
    ticks(1); live("R8 unfrozen", 16'd4);
    wr(2'd0, 16'h0001);
    freezeIn = 1'b1;
    ticks(1); live("R8 freeze not allowed", 16'd3);
    freezeIn = 1'b0;
  endtask

  task automatic t_livewr();
    logic [31:0] d;
    doReset();
    wr(2'd1, 16'd7);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h1234);
    live("R9 live write ignored", 16'd7);
    rd(2'd1, d); chk("R9 modulus untouched", d, 32'h7);
    rd(2'd0, d); chk("R9 ctrl untouched", d, 32'h1);
  endtask

  task automatic t_modrun();
    doReset();
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h0001);
    ticks(1); live("R4 step", 16'd3);
    wr(2'd1, 16'd9);
    live("R10 count kept", 16'd3);
    ticks(3); live("R10 reached 0", 16'd0);
    ticks(1); live("R10 new modulus reload", 16'd9);
  endtask

  task automatic t_disable();
    doReset();
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0001);
    ticks(1); live("R4 step", 16'd1);
    wr(2'd0, 16'h0000);
    ticks(3); live("R3 hold when disabled", 16'd1);
    wr(2'd0, 16'h0001);
    live("R3 reload on re-enable", 16'd2);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_period();
    t_collide();
    t_irq();
    t_freeze();
    t_livewr();
    t_modrun();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule